// File: doc/BRIEF.md
# Shift, Rotate and Byte-Swap Execution Unit

This unit runs the single-register shift-class instructions of a 16-bit processor core. Each instruction names one of the four low registers. Depending on the instruction, the unit exchanges that register's bytes, shifts it, or rotates it through the carry and overflow flags, by one or two positions. The sequencer presents a 10-bit instruction word together with `in_valid`. The unit drives the read index to the register file at once and takes the read data back in the same cycle. One clock later it presents the write-back value, the destination index and the new sign, zero, carry and overflow flags, all together.

The instruction group is recognised by bits 9:6 equal to `0001`, which covers codes 0x040 to 0x07F. Bits 5:3 pick the operation: 000 byte swap, 001 shift left, 010 rotate left through carry, 011 shift left into carry, 100 logical shift right, 101 arithmetic shift right, 110 rotate right through carry, 111 arithmetic shift right into carry. Bit 2 selects two positions (1) or one position (0). Bits 1:0 name the register.

Top module: `shift_swap_unit`

## Requirements
- R1: A write-back (`wb_valid` high) occurs exactly when, on the previous clock, `in_valid` was high and `in_instr[9:6]` was `0001`. Any other code, or `in_valid` low, gives `wb_valid` low.
- R2: `rf_raddr` follows `in_instr[1:0]` combinationally, and `wb_idx` carries that same field on the write-back.
- R3: Write-back data and all four flags come from the one register stage and appear together, one cycle after the instruction is accepted.
- R4: Byte swap (bits 5:3 = 000) with bit 2 = 0 exchanges bits 15:8 with bits 7:0. With bit 2 = 1 the value is returned unchanged. Carry and overflow pass through unchanged.
- R5: Shift left (001), logical shift right (100) and arithmetic shift right (101) move the value by 1 or 2 positions. The left shift and the logical right shift fill with zeros, and the arithmetic right shift copies bit 15. Carry and overflow pass through unchanged.
- R6: Rotate left through carry (010): one position gives {a[14:0], C} with new C = a[15]. Two positions give {a[13:0], C, O} with new C = a[15] and new O = a[14].
- R7: Rotate right through carry (110): one position gives {C, a[15:1]} with new C = a[0]. Two positions give {O, C, a[15:2]} with new C = a[0] and new O = a[1].
- R8: Shift left into carry (011) and arithmetic shift right into carry (111) shift like R5 and bring nothing in from the flags. The last bit position vacated (a[15] on the left, a[0] on the right) goes to C. A two-position shift also puts the next bit (a[14] or a[1]) into O. A one-position shift leaves O unchanged.
- R9: For every operation, S equals bit 15 of the result and Z is set exactly when the result is zero.
- R10: While synchronous reset is high, `wb_valid`, `wb_data`, `wb_idx` and all flags are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_instr | input | 10 | Instruction word |
| rf_rdata | input | 16 | Register-file read data for `rf_raddr` |
| flag_c_in | input | 1 | Current carry flag |
| flag_o_in | input | 1 | Current overflow flag |
| rf_raddr | output | 2 | Register-file read index |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 2 | Write-back register index |
| wb_data | output | 16 | Write-back value |
| flag_s | output | 1 | New sign flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_o | output | 1 | New overflow flag |

## Verification
The hardest cases to reach are the two-position rotates. For these, the incoming carry and overflow land in specific bit positions while two different operand bits leave through the flags, so a swap of C and O stays hidden unless the two flags differ and the operand's edge bits differ. The directed rotate scenarios drive C and O to opposite values with operands whose boundary bits are distinct. A sweep then runs every code in the group against all four flag combinations and operands with asymmetric edge bits.

// File: rtl/shift_pkg.sv
package shift_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SWAP = 3'd0,
        OP_SLL  = 3'd1,
        OP_RLC  = 3'd2,
        OP_SLLC = 3'd3,
        OP_SLR  = 3'd4,
        OP_SAR  = 3'd5,
        OP_RRC  = 3'd6,
        OP_SARC = 3'd7
    } sh_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic o;
    } flags_t;

    typedef struct packed {
        logic       hit;
        sh_op_e     op;
        logic       twice;
        logic [1:0] sel;
    } sh_dec_t;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shift_pkg::*;
#(
    parameter int INSTR_W = 10,
    parameter int SEL_W   = 2
) (
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    output sh_dec_t            dec
);
    localparam int OP_LSB  = SEL_W + 1;
    localparam int TAG_LSB = OP_LSB + OP_W;
    localparam int TAG_W   = INSTR_W - TAG_LSB;
    localparam logic [TAG_W-1:0] GROUP_TAG = TAG_W'(1);

    always_comb begin
        dec.hit   = valid && (instr[INSTR_W-1:TAG_LSB] == GROUP_TAG);
        dec.op    = sh_op_e'(instr[TAG_LSB-1:OP_LSB]);
        dec.twice = instr[SEL_W];
        dec.sel   = instr[SEL_W-1:0];
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sh_op_e            op,
    input  logic              twice,
    input  logic [DATA_W-1:0] a,
    input  logic              c_in,
    input  logic              o_in,
    output logic [DATA_W-1:0] y,
    output flags_t            f
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W-1:0] lsh, rsh, ash;

    always_comb begin
        lsh = twice ? (a << 2) : (a << 1);
        rsh = twice ? (a >> 2) : (a >> 1);
        ash = twice ? DATA_W'($signed(a) >>> 2) : DATA_W'($signed(a) >>> 1);
    end

    always_comb begin
        y   = a;
        f.c = c_in;
        f.o = o_in;
        unique case (op)
            OP_SWAP: y = twice ? a : {a[HALF-1:0], a[MSB:HALF]};
            OP_SLL:  y = lsh;
            OP_SLR:  y = rsh;
            OP_SAR:  y = ash;
            OP_SLLC: begin
                y   = lsh;
                f.c = a[MSB];
                if (twice) f.o = a[MSB-1];
            end
            OP_SARC: begin
                y   = ash;
                f.c = a[0];
                if (twice) f.o = a[1];
            end
            OP_RLC: begin
                f.c = a[MSB];
                if (twice) begin
                    y   = {a[MSB-2:0], c_in, o_in};
                    f.o = a[MSB-1];
                end else begin
                    y   = {a[MSB-1:0], c_in};
                end
            end
            OP_RRC: begin
                f.c = a[0];
                if (twice) begin
                    y   = {o_in, c_in, a[MSB:2]};
                    f.o = a[1];
                end else begin
                    y   = {c_in, a[MSB:1]};
                end
            end
            default: y = a;
        endcase
        f.s = y[MSB];
        f.z = (y == '0);
    end
endmodule

// File: rtl/shift_swap_unit.sv
module shift_swap_unit
    import shift_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int INSTR_W = 10,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [DATA_W-1:0]  rf_rdata,
    input  logic               flag_c_in,
    input  logic               flag_o_in,
    output logic [SEL_W-1:0]   rf_raddr,
    output logic               wb_valid,
    output logic [SEL_W-1:0]   wb_idx,
    output logic [DATA_W-1:0]  wb_data,
    output logic               flag_s,
    output logic               flag_z,
    output logic               flag_c,
    output logic               flag_o
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    sh_dec_t           dec;
    logic [DATA_W-1:0] res;
    flags_t            nf;
    flags_t            fq;

    shift_decode #(.INSTR_W(INSTR_W), .SEL_W(SEL_W)) u_dec (
        .valid (in_valid),
        .instr (in_instr),
        .dec   (dec)
    );

    shift_core #(.DATA_W(DATA_W)) u_core (
        .op    (dec.op),
        .twice (dec.twice),
        .a     (rf_rdata),
        .c_in  (flag_c_in),
        .o_in  (flag_o_in),
        .y     (res),
        .f     (nf)
    );

    assign rf_raddr = in_instr[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
            fq       <= '0;
        end else begin
            wb_valid <= dec.hit;
            if (dec.hit) begin
                wb_idx  <= dec.sel;
                wb_data <= res;
                fq      <= nf;
            end
        end
    end

    assign flag_s = fq.s;
    assign flag_z = fq.z;
    assign flag_c = fq.c;
    assign flag_o = fq.o;

    logic in_group;
    assign in_group = in_valid && (in_instr[INSTR_W-1:6] == 4'b0001);

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_group |=> wb_valid);

    // R1
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        !in_group |=> !wb_valid);

    // R2
    index_chk: assert property (@(posedge clk) disable iff (rst)
        in_group |=> wb_idx == $past(in_instr[SEL_W-1:0]));

    // R4
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_group && in_instr[5:2] == 4'b0000) |=>
            wb_data == {$past(rf_rdata[HALF-1:0]), $past(rf_rdata[MSB:HALF])});

    // R5
    slr_chk: assert property (@(posedge clk) disable iff (rst)
        (in_group && in_instr[5:3] == 3'b100) |=>
            (!wb_data[MSB] && flag_c == $past(flag_c_in) && flag_o == $past(flag_o_in)));

    // R9
    zero_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (flag_z == (wb_data == '0)) && (flag_s == wb_data[MSB]));
endmodule

// File: tb/sim_shift_swap_unit.sv
module sim_shift_swap_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [9:0]  in_instr;
    logic [15:0] rf_rdata;
    logic        flag_c_in, flag_o_in;
    logic [1:0]  rf_raddr, wb_idx;
    logic        wb_valid;
    logic [15:0] wb_data;
    logic        flag_s, flag_z, flag_c, flag_o;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_swap_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .rf_rdata(rf_rdata), .flag_c_in(flag_c_in), .flag_o_in(flag_o_in),
        .rf_raddr(rf_raddr), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_data(wb_data), .flag_s(flag_s), .flag_z(flag_z),
        .flag_c(flag_c), .flag_o(flag_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference from the requirement text; result {y, S, Z, C, O}
    function automatic logic [19:0] ref_model(input logic [9:0] ins, input logic [15:0] a,
                                              input logic c, input logic o);
        logic [15:0] y;
        logic nc, no;
        logic two;
        two = ins[2];
        nc = c; no = o;
        case (ins[5:3])
            3'd0: y = two ? a : {a[7:0], a[15:8]};
            3'd1: y = two ? {a[13:0], 2'b00} : {a[14:0], 1'b0};
            3'd2: begin
                nc = a[15];
                if (two) begin y = {a[13:0], c, o}; no = a[14]; end
                else y = {a[14:0], c};
            end
            3'd3: begin
                y = two ? {a[13:0], 2'b00} : {a[14:0], 1'b0};
                nc = a[15];
                if (two) no = a[14];
            end
            3'd4: y = two ? {2'b00, a[15:2]} : {1'b0, a[15:1]};
            3'd5: y = two ? {{2{a[15]}}, a[15:2]} : {a[15], a[15:1]};
            3'd6: begin
                nc = a[0];
                if (two) begin y = {o, c, a[15:2]}; no = a[1]; end
                else y = {c, a[15:1]};
            end
            default: begin
                y = two ? {{2{a[15]}}, a[15:2]} : {a[15], a[15:1]};
                nc = a[0];
                if (two) no = a[1];
            end
        endcase
        return {y, y[15], (y == 16'h0), nc, no};
    endfunction

    // Drive one instruction, return outputs after the register stage
    task automatic issue(input logic [9:0] ins, input logic [15:0] a,
                         input logic c, input logic o, input logic v = 1'b1);
        @(negedge clk);
        in_valid = v; in_instr = ins; rf_rdata = a; flag_c_in = c; flag_o_in = o;
        #1;
        chk("R2 raddr", {30'd0, rf_raddr}, {30'd0, ins[1:0]});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [9:0] opc(input int op, input int two, input int r);
        return 10'h040 | 10'(op << 3) | 10'(two << 2) | 10'(r);
    endfunction

    task automatic expect_out(input string req, input logic [15:0] y, input logic [3:0] szco);
        chk({req, " valid"}, {31'd0, wb_valid}, 32'd1);
        chk({req, " data"}, {16'd0, wb_data}, {16'd0, y});
        chk({req, " flags SZCO"}, {28'd0, flag_s, flag_z, flag_c, flag_o}, {28'd0, szco});
    endtask

    task automatic test_reset;
        rst = 1'b1; in_valid = 1'b1; in_instr = opc(1, 0, 3);
        rf_rdata = 16'hFFFF; flag_c_in = 1'b1; flag_o_in = 1'b1;
        repeat (3) @(negedge clk);
        // R10
        chk("R10 wb_valid", {31'd0, wb_valid}, 32'd0);
        chk("R10 data", {16'd0, wb_data}, 32'd0);
        chk("R10 idx flags", {26'd0, wb_idx, flag_s, flag_z, flag_c, flag_o}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_swap;
        issue(opc(0, 0, 2), 16'h12AB, 1'b1, 1'b0);
        expect_out("R4 swap once", 16'hAB12, 4'b1010);
        chk("R2 wb_idx", {30'd0, wb_idx}, 32'd2);
        issue(opc(0, 1, 1), 16'h12AB, 1'b0, 1'b1);
        expect_out("R4 swap twice", 16'h12AB, 4'b0001);
        issue(opc(0, 0, 0), 16'h0080, 1'b0, 1'b0);
        expect_out("R9 swap sign", 16'h8000, 4'b1000);
    endtask

    task automatic test_plain_shifts;
        issue(opc(1, 0, 3), 16'h4001, 1'b0, 1'b1);
        expect_out("R5 sll1", 16'h8002, 4'b1001);
        issue(opc(1, 1, 0), 16'hC000, 1'b1, 1'b0);
        expect_out("R5 sll2 zero", 16'h0000, 4'b0110);
        issue(opc(4, 0, 1), 16'h8001, 1'b0, 1'b0);
        expect_out("R5 slr1", 16'h4000, 4'b0000);
        issue(opc(5, 1, 2), 16'h8004, 1'b1, 1'b1);
        expect_out("R5 sar2", 16'hE001, 4'b1011);
    endtask

    task automatic test_rotates;
        issue(opc(2, 0, 0), 16'h8000, 1'b1, 1'b0);
        expect_out("R6 rlc1", 16'h0001, 4'b0010);
        issue(opc(2, 1, 0), 16'h4000, 1'b1, 1'b0);
        expect_out("R6 rlc2", 16'h0002, 4'b0001);
        issue(opc(6, 0, 3), 16'h0001, 1'b0, 1'b1);
        expect_out("R7 rrc1", 16'h0000, 4'b0111);
        issue(opc(6, 1, 3), 16'h0002, 1'b1, 1'b0);
        expect_out("R7 rrc2", 16'h4000, 4'b0001);
    endtask

    task automatic test_carry_shifts;
        issue(opc(3, 1, 1), 16'hC000, 1'b0, 1'b0);
        expect_out("R8 sllc2", 16'h0000, 4'b0111);
        issue(opc(7, 0, 2), 16'h8001, 1'b0, 1'b1);
        expect_out("R8 sarc1", 16'hC000, 4'b1011);
    endtask

    task automatic test_reject;
        issue(10'h03F, 16'h1234, 1'b0, 1'b0);
        chk("R1 below range", {31'd0, wb_valid}, 32'd0);
        issue(10'h080, 16'h1234, 1'b0, 1'b0);
        chk("R1 above range", {31'd0, wb_valid}, 32'd0);
        issue(opc(1, 0, 0), 16'h1234, 1'b0, 1'b0, 1'b0);
        chk("R1 not valid", {31'd0, wb_valid}, 32'd0);
    endtask

    task automatic test_latency;
        @(negedge clk);
        in_valid = 1'b1; in_instr = opc(4, 1, 1); rf_rdata = 16'hF00F;
        flag_c_in = 1'b1; flag_o_in = 1'b0;
        // R3: nothing before the edge
        chk("R3 before edge", {31'd0, wb_valid}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R3 one cycle", 16'h3C03, 4'b0010);
        @(negedge clk);
        chk("R3 single pulse", {31'd0, wb_valid}, 32'd0);
    endtask

    task automatic test_sweep;
        logic [15:0] pats [4];
        logic [19:0] e;
        pats[0] = 16'h8001; pats[1] = 16'h4002; pats[2] = 16'hA55A; pats[3] = 16'h0003;
        for (int code = 10'h040; code <= 10'h07F; code++) begin
            for (int p = 0; p < 4; p++) begin
                for (int fl = 0; fl < 4; fl++) begin
                    e = ref_model(10'(code), pats[p], fl[1], fl[0]);
                    issue(10'(code), pats[p], fl[1], fl[0]);
                    // R6 R7 R8 R9 sweep against requirement model
                    chk($sformatf("R9 sweep code=%h", code),
                        {11'd0, wb_valid, wb_data, flag_s, flag_z, flag_c, flag_o},
                        {11'd0, 1'b1, e});
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL R3 watchdog actual=hung expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        in_valid = 1'b0; in_instr = '0; rf_rdata = '0;
        flag_c_in = 1'b0; flag_o_in = 1'b0; rst = 1'b1;
        test_reset();
        test_swap();
        test_plain_shifts();
        test_rotates();
        test_carry_shifts();
        test_reject();
        test_latency();
        test_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule